// File: doc/BRIEF.md
# Lockable Low-Power Control Register

This block is the software-visible configuration slice of a power controller. It stores the low-power hint, the clock enables used in the low-power and active states, and the main power domain control. It then presents them to the power sequencer as plain output levels. Software reaches the slice through a simple register bus with address, write strobe, write data and read data. Reads are combinational. A write takes effect at the clock edge on which it is presented.

Hardware owns a write-enable lock. The lock drops when low-power entry begins, so the configuration cannot move under the sequencer. It rises again when the chip is back in the active state, whatever the cause of the return. Software can read the lock at its own address but can never change it. The hint bit also clears itself when entry begins or when a valid reset request is registered, so a stale hint cannot send the chip into low power twice.

Top module: `lp_ctrl_reg`

## Requirements
- R1: After reset the lock reads 1, the hint is 0, the core-clock, IO-clock and USB low-power clock enables are 0, the USB active-state clock enable is 1, and the main-domain keep-powered bit is 1, so the control word reads 0x180.
- R2: A pulse on `lp_entry_i` makes the lock read 0 from the next cycle. If `lp_exit_i` is high in the same cycle, entry wins and the lock goes to 0.
- R3: A pulse on `lp_exit_i` without `lp_entry_i` makes the lock read 1 from the next cycle.
- R4: The lock sits at bit 0 of address `LOCK_ADDR` and its other bits read 0. A bus write to that address has no effect on the lock.
- R5: While the lock is 0, bus writes to the control address leave every stored control field unchanged.
- R6: The control word at `CTRL_ADDR` holds the hint at bit 0, core clock in low power at bit 4, IO clock in low power at bit 5, USB clock in low power at bit 6, USB clock in active at bit 7, and main domain keep-powered (active-low power-down) at bit 8. An unlocked write updates these fields and the outputs from the next cycle, and they read back unchanged.
- R7: The hint clears on the cycle after `lp_entry_i` or `rst_req_i` is high. If a software write of 1 to the hint arrives in the same cycle, the clear wins, while the other fields of that write still take effect.
- R8: `usb_clk_lp_o` is 0 whenever bit 8 is 0, whatever bit 6 holds. Bit 6 still reads back as written.
- R9: Control bits other than 0 and 4 to 8 read as 0 and discard writes. Any address other than the two mapped ones reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | ADDR_W | Register address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for the current address |
| lp_entry_i | input | 1 | Low-power entry is starting |
| lp_exit_i | input | 1 | Returned to the active state |
| rst_req_i | input | 1 | A valid reset request was registered |
| hint_o | output | 1 | Low-power hint |
| core_clk_lp_o | output | 1 | Core clock enabled in low power |
| io_clk_lp_o | output | 1 | IO clock enabled in low power |
| usb_clk_lp_o | output | 1 | Effective USB clock enable in low power |
| usb_clk_act_o | output | 1 | USB clock enabled in active state |
| main_pd_n_o | output | 1 | Main domain kept powered in low power |
| cfg_unlocked_o | output | 1 | Current lock bit (1 means writable) |

## Verification
Every stored result is one register away from its cause. A write or a hardware event presented before a rising edge shows up in both the read data and the outputs from that edge on. The gated USB enable and the read data themselves are combinational, with no extra delay. The bench changes inputs on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge, so each check lands in the first cycle where the new value is due. Same-cycle conflicts, such as a hardware clear against a write or entry against exit, are applied inside a single such window.

// File: rtl/lp_ctrl_reg.sv
module lp_ctrl_reg #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int LOCK_ADDR = 0,
  parameter int CTRL_ADDR = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              lp_entry_i,
  input  logic              lp_exit_i,
  input  logic              rst_req_i,
  output logic              hint_o,
  output logic              core_clk_lp_o,
  output logic              io_clk_lp_o,
  output logic              usb_clk_lp_o,
  output logic              usb_clk_act_o,
  output logic              main_pd_n_o
  ,output logic             cfg_unlocked_o
);

  localparam int BIT_HINT = 0;
  localparam int BIT_CORE = 4;
  localparam int BIT_IO   = 5;
  localparam int BIT_ULP  = 6;
  localparam int BIT_UACT = 7;
  localparam int BIT_MPD  = 8;

  logic lock_q;
  logic hint_q, core_q, io_q, ulp_q, uact_q, mpd_q;

  logic sel_ctrl, sel_lock, ctrl_wr, hint_clr;

  assign sel_ctrl = (bus_addr_i == ADDR_W'(CTRL_ADDR));
  assign sel_lock = (bus_addr_i == ADDR_W'(LOCK_ADDR));
  assign ctrl_wr  = bus_we_i && sel_ctrl && lock_q;
  assign hint_clr = lp_entry_i || rst_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         lock_q <= 1'b1;
    else if (lp_entry_i) lock_q <= 1'b0;
    else if (lp_exit_i)  lock_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hint_q <= 1'b0;
    else if (hint_clr) hint_q <= 1'b0;
    else if (ctrl_wr)  hint_q <= bus_wdata_i[BIT_HINT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      core_q <= 1'b0;
      io_q   <= 1'b0;
      ulp_q  <= 1'b0;
      uact_q <= 1'b1;
      mpd_q  <= 1'b1;
    end else if (ctrl_wr) begin
      core_q <= bus_wdata_i[BIT_CORE];
      io_q   <= bus_wdata_i[BIT_IO];
      ulp_q  <= bus_wdata_i[BIT_ULP];
      uact_q <= bus_wdata_i[BIT_UACT];
      mpd_q  <= bus_wdata_i[BIT_MPD];
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (sel_ctrl) begin
      bus_rdata_o[BIT_HINT] = hint_q;
      bus_rdata_o[BIT_CORE] = core_q;
      bus_rdata_o[BIT_IO]   = io_q;
      bus_rdata_o[BIT_ULP]  = ulp_q;
      bus_rdata_o[BIT_UACT] = uact_q;
      bus_rdata_o[BIT_MPD]  = mpd_q;
    end else if (sel_lock) begin
      bus_rdata_o[0] = lock_q;
    end
  end

  assign hint_o         = hint_q;
  assign core_clk_lp_o  = core_q;
  assign io_clk_lp_o    = io_q;
  assign usb_clk_lp_o   = ulp_q & mpd_q;
  assign usb_clk_act_o  = uact_q;
  assign main_pd_n_o    = mpd_q;
  assign cfg_unlocked_o = lock_q;

  a_r2_entry_locks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_entry_i |=> !cfg_unlocked_o);

  a_r3_exit_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_exit_i && !lp_entry_i) |=> cfg_unlocked_o);

  a_r5_locked_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_unlocked_o |=> ($stable(core_clk_lp_o) && $stable(io_clk_lp_o) &&
                         $stable(usb_clk_act_o) && $stable(main_pd_n_o)));

  a_r7_hint_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_entry_i || rst_req_i) |=> !hint_o);

  a_r8_usb_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !main_pd_n_o |-> !usb_clk_lp_o);

endmodule

// File: tb/test_lp_ctrl_reg.sv
module test_lp_ctrl_reg;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam logic [AW-1:0] A_LOCK = 4'd0;
  localparam logic [AW-1:0] A_CTRL = 4'd1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic we = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic entry = 1'b0, exit_s = 1'b0, rreq = 1'b0;
  logic hint, core, io, ulp, uact, mpd, unl;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lp_ctrl_reg #(.ADDR_W(AW), .DATA_W(DW), .LOCK_ADDR(0), .CTRL_ADDR(1)) i_lp_ctrl_reg (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .lp_entry_i(entry),
    .lp_exit_i(exit_s), .rst_req_i(rreq), .hint_o(hint),
    .core_clk_lp_o(core), .io_clk_lp_o(io), .usb_clk_lp_o(ulp),
    .usb_clk_act_o(uact), .main_pd_n_o(mpd), .cfg_unlocked_o(unl));

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic read_chk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  // one write window: set at falling edge, one rising edge, release at next falling edge
  task automatic step(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic en, input logic ex, input logic rq);
    @(negedge clk);
    we = w; addr = a; wdata = d; entry = en; exit_s = ex; rreq = rq;
    @(negedge clk);
    we = 1'b0; entry = 1'b0; exit_s = 1'b0; rreq = 1'b0;
  endtask

  task automatic t_reset;
    read_chk("R1 ctrl word", A_CTRL, 32'h180);
    read_chk("R1 lock", A_LOCK, 32'h1);
    chk("R1 outputs", {26'd0, hint, core, io, ulp, uact, mpd}, {26'd0, 6'b000011});
  endtask

  task automatic t_write;
    step(1, A_CTRL, 32'h1F1, 0, 0, 0);
    read_chk("R6 readback", A_CTRL, 32'h1F1);
    chk("R6 outputs", {26'd0, hint, core, io, ulp, uact, mpd}, {26'd0, 6'b111111});
    step(1, A_CTRL, 32'hFFFF_FFFF, 0, 0, 0);
    read_chk("R9 unused bits", A_CTRL, 32'h1F1);
    step(1, A_CTRL, 32'h030, 0, 0, 0);
    read_chk("R6 second pattern", A_CTRL, 32'h030);
    chk("R6 second outputs", {26'd0, hint, core, io, ulp, uact, mpd}, {26'd0, 6'b011000});
  endtask

  task automatic t_usb_gate;
    step(1, A_CTRL, 32'h040, 0, 0, 0);
    chk("R8 usb lp gated", {31'd0, ulp}, 32'd0);
    read_chk("R8 bit6 readback", A_CTRL, 32'h040);
    step(1, A_CTRL, 32'h140, 0, 0, 0);
    chk("R8 usb lp open", {31'd0, ulp}, 32'd1);
  endtask

  task automatic t_lock_ro;
    step(1, A_LOCK, 32'h0, 0, 0, 0);
    read_chk("R4 lock write ignored", A_LOCK, 32'h1);
    read_chk("R9 unmapped addr", 4'd5, 32'h0);
  endtask

  task automatic t_hint_clear;
    step(1, A_CTRL, 32'h181, 0, 0, 0);
    chk("R7 hint set", {31'd0, hint}, 32'd1);
    step(0, A_CTRL, 32'h0, 0, 0, 1);
    read_chk("R7 reset req clears hint", A_CTRL, 32'h180);
    step(1, A_CTRL, 32'h1F1, 0, 0, 1);
    read_chk("R7 clear beats write", A_CTRL, 32'h1F0);
  endtask

  task automatic t_lp_cycle;
    step(1, A_CTRL, 32'h081, 0, 0, 0);
    step(0, A_CTRL, 32'h0, 1, 0, 0);
    read_chk("R2 lock cleared", A_LOCK, 32'h0);
    read_chk("R7 entry clears hint", A_CTRL, 32'h080);
    step(1, A_CTRL, 32'h1F1, 0, 0, 0);
    read_chk("R5 locked write ignored", A_CTRL, 32'h080);
    chk("R5 outputs frozen", {26'd0, hint, core, io, ulp, uact, mpd}, {26'd0, 6'b000010});
    step(0, A_CTRL, 32'h0, 0, 1, 0);
    read_chk("R3 lock restored", A_LOCK, 32'h1);
    step(1, A_CTRL, 32'h100, 0, 0, 0);
    read_chk("R3 write accepted again", A_CTRL, 32'h100);
    step(0, A_CTRL, 32'h0, 1, 1, 0);
    read_chk("R2 entry wins over exit", A_LOCK, 32'h0);
    step(0, A_CTRL, 32'h0, 0, 1, 0);
    chk("R3 unlock output", {31'd0, unl}, 32'd1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write();
        t_usb_gate();
        t_lock_ro();
        t_hint_clear();
        t_lp_cycle();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule